// File: doc/BRIEF.md
# Gate and Busy Control Sequencer

This block is the control core of a multichannel charge digitiser front end. It holds the module in one of two states, ready or busy. While the module is ready, a gate may open the charge converters. When that gate ends, the module turns busy, and the digitisation and readout stages that follow are allowed to run. A clear request returns the module to ready and keeps it there for as long as the request lasts. The analogue converters and the data path sit outside this block. It sees them only through enable and strobe lines.

A gate comes from the front-panel gate input or from an internal fixed-width test pulse. Clear requests come from the front-panel clear input or from the backplane bus. The bus has an initialise line, a clear line, and a function/subaddress command qualified by a strobe. Every asynchronous input passes through one shared synchroniser bank. A busy module filters bus commands so that only data reads and clear get through. One accept flag per function code reports which commands were taken. When busy is set, two one-shot timers start. They pace the digitisation stage.

Top module: `gate_busy_seq`

## Requirements
- R1: Busy and converter release go to 0 and stay at 0 while any clear source is active. The clear sources are the panel clear, the strobe with the initialise line, the strobe with the clear line, and the strobe with function 9 at subaddress 0. Every output reacts in the third clock edge after an input change.
- R2: The converter-release output is set by an accepted gate. It is reset by clear and holds its value otherwise.
- R3: The digitisation clock enable and the readout enable are 0 while ready and 1 while busy.
- R4: On the rising edge of the strobe, function 25 at subaddress 0 starts an internal test pulse of TEST_WIDTH cycles, but only while the module is ready. That pulse acts as a gate just like the panel gate. Clear cancels the pulse.
- R5: The converter gate and pedestal injection outputs are 1 while a gate source is high, the module is ready and no clear is active.
- R6: Busy becomes 1 in the cycle after an accepted gate falls. If a clear is active in that cycle, the clear wins and busy stays 0.
- R7: While busy, neither the panel gate nor the test command opens the converter gate.
- R8: For each rising edge of the strobe, output cmd_accept_o bit f pulses for one cycle, where f is the function code. While busy, only functions 0 to 7 (reads) and function 9 (clear) are flagged.
- R9: In the cycle that busy rises, two timers go high. They stay high for TIMER_A_LEN and TIMER_B_LEN cycles. Clear stops both timers.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| panel_gate_i | input | 1 | Front-panel gate, asynchronous |
| panel_clear_i | input | 1 | Front-panel clear, asynchronous |
| bus_strobe_i | input | 1 | Bus command strobe |
| bus_init_i | input | 1 | Bus initialise line |
| bus_clear_i | input | 1 | Bus clear line |
| bus_func_i | input | 5 | Bus function code |
| bus_addr_i | input | 4 | Bus subaddress |
| busy_o | output | 1 | 1 = busy, 0 = ready |
| conv_release_o | output | 1 | 1 = converters released from clear |
| conv_gate_o | output | 1 | Converter gate enable |
| ped_inject_o | output | 1 | Pedestal injection enable |
| dig_clk_en_o | output | 1 | Digitisation clock enable |
| readout_en_o | output | 1 | Readout enable |
| test_pulse_o | output | 1 | Internal test gate pulse |
| dig_timer_o | output | 2 | Digitisation-control one-shots |
| cmd_accept_o | output | 32 | One-hot accepted-function flag |

## Verification
The main cycle is driven in four ways: a panel gate, a bus test command, a gate that overlaps a clear from start to end, and a gate whose falling edge lands in the same cycle as a rising clear. The first two show that both gate sources lead to the same busy transition. The last two tell clear priority apart from ordinary busy entry. The module is returned to ready by each clear source in turn: panel clear, bus initialise, bus clear and function 9. Commands are sent both while busy and while ready, which separates filtering from plain decoding. A clear in the middle of a timer run shows that both timers stop.

// File: rtl/gbs_pkg.sv
package gbs_pkg;
  localparam int FUNC_W   = 5;
  localparam int ADDR_W   = 4;
  localparam int NUM_FUNC = 1 << FUNC_W;

  localparam logic [FUNC_W-1:0] F_CLEAR      = FUNC_W'(9);
  localparam logic [FUNC_W-1:0] F_TEST       = FUNC_W'(25);
  localparam logic [FUNC_W-1:0] F_READ_LIMIT = FUNC_W'(8);

  typedef struct packed {
    logic              stb;
    logic              init;
    logic              clr;
    logic [FUNC_W-1:0] func;
    logic [ADDR_W-1:0] addr;
  } bus_cmd_t;

  localparam int CMD_W = $bits(bus_cmd_t);
endpackage

// File: rtl/gbs_sync.sv
module gbs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gbs_oneshot.sv
module gbs_oneshot #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || abort)     cnt <= '0;
    else if (trig)        cnt <= CW'(LEN);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign active = (cnt != '0);

  AST_ONESHOT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LEN)); // R9
  AST_ONESHOT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (trig && !abort) |=> active); // R4
  AST_ONESHOT_ABORT: assert property (@(posedge clk) disable iff (rst)
    abort |=> !active); // R9
endmodule

// File: rtl/gbs_cmd_filter.sv
module gbs_cmd_filter
  import gbs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                stb_rise,
  input  logic                busy,
  input  logic [FUNC_W-1:0]   func,
  output logic [NUM_FUNC-1:0] accept
);
  logic allow;

  always_comb begin
    allow = !busy || (func < F_READ_LIMIT) || (func == F_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (rst)                    accept <= '0;
    else if (stb_rise && allow) accept <= NUM_FUNC'(1) << func;
    else                        accept <= '0;
  end

  AST_ACCEPT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(accept)); // R8
  AST_TEST_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept[F_TEST] |-> !$past(busy)); // R8
endmodule

// File: rtl/gate_busy_seq.sv
module gate_busy_seq
  import gbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TEST_WIDTH  = 6,
  parameter int TIMER_A_LEN = 20,
  parameter int TIMER_B_LEN = 35
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                panel_gate_i,
  input  logic                panel_clear_i,
  input  logic                bus_strobe_i,
  input  logic                bus_init_i,
  input  logic                bus_clear_i,
  input  logic [FUNC_W-1:0]   bus_func_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  output logic                busy_o,
  output logic                conv_release_o,
  output logic                conv_gate_o,
  output logic                ped_inject_o,
  output logic                dig_clk_en_o,
  output logic                readout_en_o,
  output logic                test_pulse_o,
  output logic [1:0]          dig_timer_o,
  output logic [NUM_FUNC-1:0] cmd_accept_o
);
  localparam int SW = 2 + CMD_W;

  // synchronised view of every asynchronous input
  logic [SW-1:0] raw_in, sync_q;
  logic          gate_s, pclr_s;
  bus_cmd_t      cmd_s;

  assign raw_in = {panel_gate_i, panel_clear_i,
                   bus_strobe_i, bus_init_i, bus_clear_i, bus_func_i, bus_addr_i};

  gbs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_q)
  );

  assign {gate_s, pclr_s, cmd_s} = sync_q;

  // state
  logic stb_prev, gate_en_q, ped_q, rel_q, busy_q;
  logic test_act;

  // decoded conditions
  logic bus_clr, clear_req, stb_rise, gate_src, gate_act, set_busy, test_fire;

  always_comb begin
    bus_clr   = cmd_s.stb && (cmd_s.init || cmd_s.clr ||
                              (cmd_s.func == F_CLEAR && cmd_s.addr == '0));
    clear_req = pclr_s || bus_clr;
    stb_rise  = cmd_s.stb && !stb_prev;
    gate_src  = gate_s || test_act;
    gate_act  = gate_src && !busy_q && !clear_req;
    set_busy  = !clear_req && gate_en_q && !gate_src;
    test_fire = stb_rise && !busy_q && !clear_req &&
                cmd_s.func == F_TEST && cmd_s.addr == '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_prev  <= 1'b0;
      gate_en_q <= 1'b0;
      ped_q     <= 1'b0;
      rel_q     <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      stb_prev  <= cmd_s.stb;
      gate_en_q <= gate_act;
      ped_q     <= gate_act;
      if (clear_req)     rel_q <= 1'b0;
      else if (gate_act) rel_q <= 1'b1;
      if (clear_req)     busy_q <= 1'b0;
      else if (set_busy) busy_q <= 1'b1;
    end
  end

  // internal test gate generator
  gbs_oneshot #(.LEN(TEST_WIDTH)) u_test (
    .clk    (clk),
    .rst    (rst),
    .abort  (clear_req),
    .trig   (test_fire),
    .active (test_act)
  );

  // digitisation-control one-shots
  for (genvar i = 0; i < 2; i++) begin : g_timer
    localparam int LEN_I = (i == 0) ? TIMER_A_LEN : TIMER_B_LEN;
    gbs_oneshot #(.LEN(LEN_I)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .abort  (clear_req),
      .trig   (set_busy),
      .active (dig_timer_o[i])
    );
  end

  gbs_cmd_filter u_filter (
    .clk      (clk),
    .rst      (rst),
    .stb_rise (stb_rise),
    .busy     (busy_q),
    .func     (cmd_s.func),
    .accept   (cmd_accept_o)
  );

  assign busy_o         = busy_q;
  assign conv_release_o = rel_q;
  assign conv_gate_o    = gate_en_q;
  assign ped_inject_o   = ped_q;
  assign dig_clk_en_o   = busy_q;
  assign readout_en_o   = busy_q;
  assign test_pulse_o   = test_act;

  AST_CLEAR_FORCES_READY: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> (!busy_q && !rel_q)); // R1
  AST_RELEASE_ON_GATE: assert property (@(posedge clk) disable iff (rst)
    gate_en_q |-> rel_q); // R2
  AST_BUSY_ON_TRAIL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> ($past(gate_en_q) && !$past(gate_src))); // R6
  AST_BUSY_BLOCKS_GATE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (!gate_en_q && !ped_q)); // R7
  AST_TIMERS_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> (&dig_timer_o)); // R9
endmodule

// File: tb/gate_busy_seq_test.sv
`timescale 1ns/1ps
module gate_busy_seq_test;
  localparam int TW = 6;
  localparam int TA = 20;
  localparam int TB = 35;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg = 0, pc = 0, stb = 0, zi = 0, ci = 0;
  logic [4:0] fn = '0;
  logic [3:0] ad = '0;

  logic busy, rel, cg, ped, dce, roe, tp;
  logic [1:0] tmr;
  logic [31:0] acc;

  always #2.5 clk = ~clk;

  gate_busy_seq #(.TEST_WIDTH(TW), .TIMER_A_LEN(TA), .TIMER_B_LEN(TB)) uut (
    .clk(clk), .rst(rst),
    .panel_gate_i(pg), .panel_clear_i(pc),
    .bus_strobe_i(stb), .bus_init_i(zi), .bus_clear_i(ci),
    .bus_func_i(fn), .bus_addr_i(ad),
    .busy_o(busy), .conv_release_o(rel), .conv_gate_o(cg), .ped_inject_o(ped),
    .dig_clk_en_o(dce), .readout_en_o(roe), .test_pulse_o(tp),
    .dig_timer_o(tmr), .cmd_accept_o(acc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input string nm, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, nm, $time, act, exp);
    end
  endtask

  // behavioural reference: delay line for the synchroniser, integers for state
  logic [13:0] pipe[$];
  int m_busy, m_rel, m_gate, m_tcnt, m_ta, m_tb, m_sprev, m_clr;
  logic [31:0] m_acc;

  always @(posedge clk) begin
    if (rst) begin
      pipe = '{14'h0, 14'h0};
      m_busy = 0; m_rel = 0; m_gate = 0; m_tcnt = 0; m_ta = 0; m_tb = 0;
      m_sprev = 0; m_acc = '0; m_clr = 0;
    end else begin
      logic [13:0] s;
      int g, k, sb, z, c, f, a, edge_seen, allow, gsrc, act, setb, fire;
      s = pipe.pop_front();
      pipe.push_back({pg, pc, stb, zi, ci, fn, ad});
      g = s[13]; k = s[12]; sb = s[11]; z = s[10]; c = s[9];
      f = int'(s[8:4]); a = int'(s[3:0]);
      m_clr = (k || (sb && (z || c || (f == 9 && a == 0)))) ? 1 : 0;
      edge_seen = (sb && !m_sprev) ? 1 : 0;
      allow = (m_busy == 0 || f < 8 || f == 9) ? 1 : 0;
      gsrc = (g || m_tcnt > 0) ? 1 : 0;
      act = (gsrc && !m_busy && !m_clr) ? 1 : 0;
      setb = (!m_clr && m_gate && !gsrc) ? 1 : 0;
      fire = (edge_seen && !m_busy && !m_clr && f == 25 && a == 0) ? 1 : 0;
      m_acc = (edge_seen && allow) ? (32'd1 << f) : 32'd0;
      if (m_clr) begin m_tcnt = 0; m_ta = 0; m_tb = 0; end
      else begin
        if (fire) m_tcnt = TW; else if (m_tcnt > 0) m_tcnt--;
        if (setb) begin m_ta = TA; m_tb = TB; end
        else begin if (m_ta > 0) m_ta--; if (m_tb > 0) m_tb--; end
      end
      if (m_clr) m_busy = 0; else if (setb) m_busy = 1;
      if (m_clr) m_rel = 0; else if (act) m_rel = 1;
      m_gate = act;
      m_sprev = sb;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(m_clr ? "R1" : "R6", "busy", busy, m_busy);
      chk("R2", "release", rel, m_rel);
      chk((pg && m_busy) ? "R7" : "R5", "conv_gate", cg, m_gate);
      chk("R5", "pedestal", ped, m_gate);
      chk("R3", "dig_clk_en", dce, m_busy);
      chk("R3", "readout_en", roe, m_busy);
      chk("R4", "test_pulse", tp, m_tcnt > 0);
      chk("R9", "timer_a", tmr[0], m_ta > 0);
      chk("R9", "timer_b", tmr[1], m_tb > 0);
      chk("R8", "accept", acc, m_acc);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_cmd(input int f, input int a, input bit z, input bit c, input int hold);
    @(negedge clk);
    fn = 5'(f); ad = 4'(a); zi = z; ci = c; stb = 1;
    wait_cyc(hold);
    stb = 0;
    wait_cyc(4);
    zi = 0; ci = 0;
  endtask

  task automatic gate_pulse(input int len);
    @(negedge clk); pg = 1;
    wait_cyc(len);
    pg = 0;
  endtask

  task automatic panel_clear(input int len);
    @(negedge clk); pc = 1;
    wait_cyc(len);
    pc = 0;
  endtask

  initial begin
    wait_cyc(4);
    // R10: reset state at the ports
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset release", rel, 0);
    chk("R10", "reset gate", {cg, ped, dce, roe, tp}, 0);
    chk("R10", "reset timers", tmr, 0);
    chk("R10", "reset accept", acc, 0);
    rst = 0;
    wait_cyc(3);

    // panel gate -> busy, then command filtering while busy (R7, R8)
    gate_pulse(6);
    wait_cyc(4);
    gate_pulse(4);
    bus_cmd(0, 0, 0, 0, 2);
    bus_cmd(2, 3, 0, 0, 2);
    bus_cmd(25, 0, 0, 0, 2);
    bus_cmd(16, 0, 0, 0, 2);
    bus_cmd(9, 1, 0, 0, 2);
    wait_cyc(40);
    panel_clear(3);
    wait_cyc(6);

    // test command as gate source (R4), function 9 clear (R1)
    bus_cmd(25, 0, 0, 0, 2);
    wait_cyc(45);
    bus_cmd(9, 0, 0, 0, 3);
    wait_cyc(5);

    // bus initialise and bus clear lines (R1)
    gate_pulse(5);
    wait_cyc(10);
    bus_cmd(16, 0, 1, 0, 3);
    wait_cyc(5);
    gate_pulse(5);
    wait_cyc(10);
    bus_cmd(3, 0, 0, 1, 3);
    wait_cyc(5);

    // gate fully overlapped by clear: never busy (R6)
    @(negedge clk); pg = 1; pc = 1;
    wait_cyc(4); pg = 0;
    wait_cyc(3); pc = 0;
    wait_cyc(6);

    // gate falls in the same cycle clear rises: clear wins (R6)
    @(negedge clk); pg = 1;
    wait_cyc(5); pg = 0; pc = 1;
    wait_cyc(3); pc = 0;
    wait_cyc(6);

    // clear part-way through the timers (R9)
    gate_pulse(4);
    wait_cyc(8);
    panel_clear(2);
    wait_cyc(6);

    // commands while ready, test at wrong subaddress (R8)
    bus_cmd(16, 0, 0, 0, 2);
    bus_cmd(25, 1, 0, 0, 2);
    wait_cyc(10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule